// File: doc/BRIEF.md
# Bus Transaction ID Filter

This block sits in front of three event counters of a memory-bus performance monitor. It observes three ID-tagged handshakes: read address acceptances, write address acceptances and read data beats. For each, it produces a one-cycle qualified event pulse when the ID on that handshake matches a programmed ID under a programmed mask. Each of the three streams has its own enable. A disabled stream never pulses. The downstream counters for read transactions, write transactions and read beats take these pulses as their filtered event.

Software programs the block through a simple register write port that holds two configuration words. The control word (offset 0x00) carries the three enables and the 18-bit ID mask. The match word (offset 0x04) carries the 18-bit ID to compare against. The enables are meant to be set only while the associated counter is programmed for the filtered event, and the block obeys whatever value is written. A transaction or beat qualifies when (bus ID AND mask) equals (programmed ID AND mask). The pulse appears on the output register one clock after the qualifying handshake.

Top module: `idf_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all three outputs are low. Reset clears all three enables, the mask and the match ID.
- R2: A handshake matches when (handshake ID AND mask) equals (match ID AND mask), compared bitwise over 18 bits. With a mask of zero, every ID matches.
- R3: Bit 31 of the control word (offset 0x00) enables the read-transaction lane. When it is set, a matching accepted read address handshake makes `flt_rd_txn` high for exactly the next cycle.
- R4: Bit 30 of the control word enables the write-transaction lane. When it is set, a matching accepted write address handshake makes `flt_wr_txn` high for exactly the next cycle.
- R5: Bit 29 of the control word enables the read-beat lane. When it is set, a matching accepted read data beat makes `flt_rd_beat` high for exactly the next cycle. The compare uses the ID carried with the beat, independent of the read address ID in the same cycle.
- R6: A handshake counts only when valid and ready are both high in the same cycle. Valid alone or ready alone produces no pulse.
- R7: With a lane's enable clear, its output stays low whatever handshakes occur. Each lane depends only on its own enable.
- R8: The mask lives in control word bits 17:0 and the match ID lives in match word (offset 0x04) bits 17:0. Other bits of both words are ignored, and writes to any other offset change nothing.
- R9: Accepted handshakes on consecutive cycles give pulses on consecutive cycles, one per handshake, each qualified on its own ID.
- R10: A configuration write takes effect for handshakes in the cycles after the write cycle. A handshake in the same cycle as the write is judged with the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_ofs | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 32 | Configuration write data |
| rd_addr_valid | input | 1 | Read address valid |
| rd_addr_ready | input | 1 | Read address ready |
| rd_addr_id | input | 18 | Read address transaction ID |
| wr_addr_valid | input | 1 | Write address valid |
| wr_addr_ready | input | 1 | Write address ready |
| wr_addr_id | input | 18 | Write address transaction ID |
| rd_data_valid | input | 1 | Read data beat valid |
| rd_data_ready | input | 1 | Read data beat ready |
| rd_data_id | input | 18 | ID carried with the read data beat |
| flt_rd_txn | output | 1 | Filtered read-transaction pulse |
| flt_wr_txn | output | 1 | Filtered write-transaction pulse |
| flt_rd_beat | output | 1 | Filtered read-beat pulse |

## Verification
The bound checker checks on every cycle that a pulse never appears without a full handshake in the previous cycle. It also checks, against a shadow of the configuration built from the write port, that every pulse had a set enable and a masked ID match, and that outputs are low right after reset. What the checker cannot show, and the directed scenarios do, is that pulses are not missing. This covers the exact mask semantics with partial and zero masks, independence of the beat ID from the address ID, ignored upper bits and stray offsets, back-to-back pulses, and a write landing in the same cycle as a handshake.

// File: rtl/idf_pkg.sv
package idf_pkg;

    localparam int ID_W      = 18;
    localparam int REG_W     = 32;
    localparam int OFS_W     = 8;
    localparam int NUM_LANES = 3;

    // Lane indices; control bit for lane l is REG_W-1-l
    localparam int LANE_RD_TXN  = 0;
    localparam int LANE_WR_TXN  = 1;
    localparam int LANE_RD_BEAT = 2;

    typedef enum logic [OFS_W-1:0] {
        REG_CTRL  = 8'h00,
        REG_MATCH = 8'h04
    } cfg_reg_e;

    typedef struct packed {
        logic [NUM_LANES-1:0] en;
        logic [ID_W-1:0]      mask;
        logic [ID_W-1:0]      match_id;
    } flt_cfg_t;

    typedef struct packed {
        logic            fire;
        logic [ID_W-1:0] id;
    } tagged_hs_t;

    function automatic int lane_ctrl_bit(input int lane);
        return REG_W - 1 - lane;
    endfunction

    function automatic logic id_hit(input logic [ID_W-1:0] id,
                                    input logic [ID_W-1:0] mask,
                                    input logic [ID_W-1:0] match_id);
        return ((id ^ match_id) & mask) == '0;
    endfunction

endpackage

// File: rtl/idf_cfg_regs.sv
module idf_cfg_regs
    import idf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [REG_W-1:0] wr_data,
    output flt_cfg_t         cfg
);

    logic hit_ctrl;
    logic hit_match;

    assign hit_ctrl  = wr_en && (wr_ofs == REG_CTRL);
    assign hit_match = wr_en && (wr_ofs == REG_MATCH);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg.en[g] <= 1'b0;
            end else if (hit_ctrl) begin
                cfg.en[g] <= wr_data[lane_ctrl_bit(g)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mask     <= '0;
            cfg.match_id <= '0;
        end else begin
            if (hit_ctrl) begin
                cfg.mask <= wr_data[ID_W-1:0];
            end
            if (hit_match) begin
                cfg.match_id <= wr_data[ID_W-1:0];
            end
        end
    end

    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[REG_W-NUM_LANES-1:ID_W];

endmodule

// File: rtl/idf_lane.sv
module idf_lane
    import idf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tagged_hs_t      hs,
    input  logic            en,
    input  logic [ID_W-1:0] mask,
    input  logic [ID_W-1:0] match_id,
    output logic            pulse
);

    logic qualify;

    assign qualify = hs.fire && en && id_hit(hs.id, mask, match_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= qualify;
        end
    end

endmodule

// File: rtl/idf_top.sv
module idf_top
    import idf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [OFS_W-1:0] cfg_wr_ofs,
    input  logic [REG_W-1:0] cfg_wr_data,
    input  logic             rd_addr_valid,
    input  logic             rd_addr_ready,
    input  logic [ID_W-1:0]  rd_addr_id,
    input  logic             wr_addr_valid,
    input  logic             wr_addr_ready,
    input  logic [ID_W-1:0]  wr_addr_id,
    input  logic             rd_data_valid,
    input  logic             rd_data_ready,
    input  logic [ID_W-1:0]  rd_data_id,
    output logic             flt_rd_txn,
    output logic             flt_wr_txn,
    output logic             flt_rd_beat
);

    flt_cfg_t             cfg;
    tagged_hs_t           hs [NUM_LANES];
    logic [NUM_LANES-1:0] pulse;

    idf_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_ofs  (cfg_wr_ofs),
        .wr_data (cfg_wr_data),
        .cfg     (cfg)
    );

    assign hs[LANE_RD_TXN]  = '{fire: rd_addr_valid & rd_addr_ready, id: rd_addr_id};
    assign hs[LANE_WR_TXN]  = '{fire: wr_addr_valid & wr_addr_ready, id: wr_addr_id};
    assign hs[LANE_RD_BEAT] = '{fire: rd_data_valid & rd_data_ready, id: rd_data_id};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        idf_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .hs       (hs[g]),
            .en       (cfg.en[g]),
            .mask     (cfg.mask),
            .match_id (cfg.match_id),
            .pulse    (pulse[g])
        );
    end

    assign flt_rd_txn  = pulse[LANE_RD_TXN];
    assign flt_wr_txn  = pulse[LANE_WR_TXN];
    assign flt_rd_beat = pulse[LANE_RD_BEAT];

endmodule

// File: rtl/idf_chk.sv
module idf_chk
    import idf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [OFS_W-1:0] cfg_wr_ofs,
    input logic [REG_W-1:0] cfg_wr_data,
    input logic             rd_addr_valid,
    input logic             rd_addr_ready,
    input logic [ID_W-1:0]  rd_addr_id,
    input logic             wr_addr_valid,
    input logic             wr_addr_ready,
    input logic [ID_W-1:0]  wr_addr_id,
    input logic             rd_data_valid,
    input logic             rd_data_ready,
    input logic [ID_W-1:0]  rd_data_id,
    input logic             flt_rd_txn,
    input logic             flt_wr_txn,
    input logic             flt_rd_beat
);

    // Shadow configuration rebuilt from the write port only
    logic            sh_en_rd, sh_en_wr, sh_en_bt;
    logic [ID_W-1:0] sh_mask, sh_id;
    logic            rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            sh_en_rd <= 1'b0;
            sh_en_wr <= 1'b0;
            sh_en_bt <= 1'b0;
            sh_mask  <= '0;
            sh_id    <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_wr_ofs == 8'h00) begin
                sh_en_rd <= cfg_wr_data[31];
                sh_en_wr <= cfg_wr_data[30];
                sh_en_bt <= cfg_wr_data[29];
                sh_mask  <= cfg_wr_data[ID_W-1:0];
            end
            if (cfg_wr_ofs == 8'h04) begin
                sh_id <= cfg_wr_data[ID_W-1:0];
            end
        end
    end

    // R1: outputs low in the cycle after reset was sampled
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_quiet: assert (!flt_rd_txn && !flt_wr_txn && !flt_rd_beat);
        end
    end

    // R6: no pulse without a full handshake one cycle earlier
    a_r6_rd_txn_needs_hs: assert property (@(posedge clk) disable iff (rst)
        flt_rd_txn |-> $past(rd_addr_valid && rd_addr_ready));
    a_r6_wr_txn_needs_hs: assert property (@(posedge clk) disable iff (rst)
        flt_wr_txn |-> $past(wr_addr_valid && wr_addr_ready));
    a_r6_rd_beat_needs_hs: assert property (@(posedge clk) disable iff (rst)
        flt_rd_beat |-> $past(rd_data_valid && rd_data_ready));

    // R7: a pulse needs its own enable
    a_r7_rd_txn_enabled: assert property (@(posedge clk) disable iff (rst)
        flt_rd_txn |-> $past(sh_en_rd));
    a_r7_wr_txn_enabled: assert property (@(posedge clk) disable iff (rst)
        flt_wr_txn |-> $past(sh_en_wr));
    a_r7_rd_beat_enabled: assert property (@(posedge clk) disable iff (rst)
        flt_rd_beat |-> $past(sh_en_bt));

    // R2: a pulse needs a masked ID match on its own stream's ID
    a_r2_rd_txn_match: assert property (@(posedge clk) disable iff (rst)
        flt_rd_txn |-> $past((rd_addr_id & sh_mask) == (sh_id & sh_mask)));
    a_r2_wr_txn_match: assert property (@(posedge clk) disable iff (rst)
        flt_wr_txn |-> $past((wr_addr_id & sh_mask) == (sh_id & sh_mask)));
    a_r5_rd_beat_match: assert property (@(posedge clk) disable iff (rst)
        flt_rd_beat |-> $past((rd_data_id & sh_mask) == (sh_id & sh_mask)));

endmodule

bind idf_top idf_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_ofs    (cfg_wr_ofs),
    .cfg_wr_data   (cfg_wr_data),
    .rd_addr_valid (rd_addr_valid),
    .rd_addr_ready (rd_addr_ready),
    .rd_addr_id    (rd_addr_id),
    .wr_addr_valid (wr_addr_valid),
    .wr_addr_ready (wr_addr_ready),
    .wr_addr_id    (wr_addr_id),
    .rd_data_valid (rd_data_valid),
    .rd_data_ready (rd_data_ready),
    .rd_data_id    (rd_data_id),
    .flt_rd_txn    (flt_rd_txn),
    .flt_wr_txn    (flt_wr_txn),
    .flt_rd_beat   (flt_rd_beat)
);

// File: tb/sim_idf_top.sv
`timescale 1ns/1ps
module sim_idf_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [7:0]  cfg_wr_ofs;
    logic [31:0] cfg_wr_data;
    logic        rd_addr_valid, rd_addr_ready;
    logic [17:0] rd_addr_id;
    logic        wr_addr_valid, wr_addr_ready;
    logic [17:0] wr_addr_id;
    logic        rd_data_valid, rd_data_ready;
    logic [17:0] rd_data_id;
    logic        flt_rd_txn, flt_wr_txn, flt_rd_beat;

    int checks = 0;
    int fails  = 0;

    // Expected configuration, kept from what the bench writes
    logic [2:0]  m_en;     // [0]=rd txn (bit31) [1]=wr txn (bit30) [2]=rd beat (bit29)
    logic [17:0] m_mask;
    logic [17:0] m_id;

    always #2.5 clk = ~clk;

    idf_top u0 (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs), .cfg_wr_data(cfg_wr_data),
        .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready), .rd_addr_id(rd_addr_id),
        .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready), .wr_addr_id(wr_addr_id),
        .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data_id(rd_data_id),
        .flt_rd_txn(flt_rd_txn), .flt_wr_txn(flt_wr_txn), .flt_rd_beat(flt_rd_beat)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [2:0] exp);
        chk(req, "flt_rd_txn", flt_rd_txn, exp[0]);
        chk(req, "flt_wr_txn", flt_wr_txn, exp[1]);
        chk(req, "flt_rd_beat", flt_rd_beat, exp[2]);
    endtask

    function automatic logic model(input int lane, input logic [17:0] id);
        return m_en[lane] && ((id & m_mask) == (m_id & m_mask));
    endfunction

    task automatic clear_inputs();
        cfg_wr_en = 1'b0; cfg_wr_ofs = '0; cfg_wr_data = '0;
        rd_addr_valid = 1'b0; rd_addr_ready = 1'b0; rd_addr_id = '0;
        wr_addr_valid = 1'b0; wr_addr_ready = 1'b0; wr_addr_id = '0;
        rd_data_valid = 1'b0; rd_data_ready = 1'b0; rd_data_id = '0;
    endtask

    task automatic model_write(input logic [7:0] ofs, input logic [31:0] data);
        if (ofs == 8'h00) begin
            m_en   = {data[29], data[30], data[31]};
            m_mask = data[17:0];
        end else if (ofs == 8'h04) begin
            m_id = data[17:0];
        end
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_ofs = ofs; cfg_wr_data = data;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        model_write(ofs, data);
    endtask

    // One cycle with per-lane valid/ready/id; check outputs after that edge
    task automatic cycle3(input string req, input logic [2:0] v, input logic [2:0] r,
                          input logic [17:0] id_rd, input logic [17:0] id_wr,
                          input logic [17:0] id_bt);
        logic [2:0] exp;
        @(negedge clk);
        rd_addr_valid = v[0]; rd_addr_ready = r[0]; rd_addr_id = id_rd;
        wr_addr_valid = v[1]; wr_addr_ready = r[1]; wr_addr_id = id_wr;
        rd_data_valid = v[2]; rd_data_ready = r[2]; rd_data_id = id_bt;
        exp[0] = v[0] && r[0] && model(0, id_rd);
        exp[1] = v[1] && r[1] && model(1, id_wr);
        exp[2] = v[2] && r[2] && model(2, id_bt);
        @(posedge clk); #1;
        chk_all(req, exp);
        rd_addr_valid = 1'b0; wr_addr_valid = 1'b0; rd_data_valid = 1'b0;
        rd_addr_ready = 1'b0; wr_addr_ready = 1'b0; rd_data_ready = 1'b0;
    endtask

    task automatic shot(input string req, input int lane, input logic [17:0] id);
        logic [2:0] b;
        b = 3'b001 << lane;
        cycle3(req, b, b, id, id, id);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        clear_inputs();
        m_en = '0; m_mask = '0; m_id = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1 during reset", 3'b000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk_all("R1 after reset", 3'b000);
        // all handshakes with reset config: enables clear, so no pulses
        cycle3("R1 enables cleared", 3'b111, 3'b111, 18'h0, 18'h0, 18'h0);
    endtask

    task automatic t_lane_enables();
        cfg_write(8'h04, 32'h0002_A5A5);
        cfg_write(8'h00, 32'h8003_FFFF);              // rd txn only
        shot("R3 rd txn match", 0, 18'h2A5A5);
        chk("R3 expected pulse", "model", model(0, 18'h2A5A5), 1'b1);
        shot("R3 rd txn mismatch", 0, 18'h2A5A4);
        shot("R7 wr txn disabled", 1, 18'h2A5A5);
        shot("R7 rd beat disabled", 2, 18'h2A5A5);
        @(posedge clk); #1;
        chk_all("R3 single-cycle pulse", 3'b000);
        cfg_write(8'h00, 32'h4003_FFFF);              // wr txn only
        shot("R4 wr txn match", 1, 18'h2A5A5);
        shot("R7 rd txn disabled", 0, 18'h2A5A5);
        cfg_write(8'h00, 32'h2003_FFFF);              // rd beat only
        shot("R5 rd beat match", 2, 18'h2A5A5);
        shot("R7 rd txn off again", 0, 18'h2A5A5);
        // beat ID used independently of address ID in same cycle
        cfg_write(8'h00, 32'hE003_FFFF);
        cycle3("R5 beat uses own id", 3'b101, 3'b101, 18'h00001, 18'h0, 18'h2A5A5);
        cycle3("R5 addr id match beat id not", 3'b101, 3'b101, 18'h2A5A5, 18'h0, 18'h00001);
    endtask

    task automatic t_mask();
        cfg_write(8'h04, 32'h0001_2345);
        cfg_write(8'h00, 32'hE000_00FF);
        cycle3("R2 low byte match", 3'b111, 3'b111, 18'h3FF45, 18'h00045, 18'h12345);
        cycle3("R2 low byte mismatch", 3'b111, 3'b111, 18'h12344, 18'h12355, 18'h3FF00);
        cfg_write(8'h00, 32'hE000_0000);
        cycle3("R2 zero mask matches all", 3'b111, 3'b111, 18'h3FFFF, 18'h00000, 18'h1ABCD);
    endtask

    task automatic t_handshake();
        cfg_write(8'h00, 32'hE000_0000);
        cycle3("R6 valid without ready", 3'b111, 3'b000, 18'h0, 18'h0, 18'h0);
        cycle3("R6 ready without valid", 3'b000, 3'b111, 18'h0, 18'h0, 18'h0);
        cycle3("R6 mixed", 3'b011, 3'b110, 18'h0, 18'h0, 18'h0);
    endtask

    task automatic t_ignored();
        cfg_write(8'h04, 32'h0000_0F0F);
        cfg_write(8'h00, 32'hFFFF_FFFF);              // upper junk bits set
        cfg_write(8'h04, 32'hFFFC_0F0F);              // same id, upper junk
        cycle3("R8 junk bits ignored", 3'b111, 3'b111, 18'h00F0F, 18'h00F0F, 18'h00F0F);
        cfg_write(8'h08, 32'h0000_0000);              // stray offset
        cfg_write(8'h40, 32'h0000_0000);
        cycle3("R8 stray offset ignored", 3'b111, 3'b111, 18'h00F0F, 18'h00F0F, 18'h00F0F);
        cycle3("R8 id still full-width", 3'b111, 3'b111, 18'h10F0F, 18'h00F0E, 18'h20F0F);
    endtask

    task automatic t_back_to_back();
        logic [17:0] ids [4];
        cfg_write(8'h04, 32'h0000_0033);
        cfg_write(8'h00, 32'hE003_FFFF);
        ids[0] = 18'h33; ids[1] = 18'h33; ids[2] = 18'h34; ids[3] = 18'h33;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd_addr_valid = 1'b1; rd_addr_ready = 1'b1; rd_addr_id = ids[i];
            rd_data_valid = 1'b1; rd_data_ready = 1'b1; rd_data_id = ids[3-i];
            @(posedge clk); #1;
            chk("R9 back-to-back rd txn", "flt_rd_txn", flt_rd_txn, ids[i] == 18'h33);
            chk("R9 back-to-back rd beat", "flt_rd_beat", flt_rd_beat, ids[3-i] == 18'h33);
        end
        @(negedge clk);
        rd_addr_valid = 1'b0; rd_addr_ready = 1'b0;
        rd_data_valid = 1'b0; rd_data_ready = 1'b0;
        @(posedge clk); #1;
        chk_all("R9 idle after burst", 3'b000);
    endtask

    task automatic t_write_timing();
        cfg_write(8'h00, 32'h0000_0000);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_ofs = 8'h00; cfg_wr_data = 32'h8000_0000;
        rd_addr_valid = 1'b1; rd_addr_ready = 1'b1; rd_addr_id = 18'h1;
        @(posedge clk); #1;
        chk("R10 same-cycle uses old cfg", "flt_rd_txn", flt_rd_txn, 1'b0);
        cfg_wr_en = 1'b0;
        model_write(8'h00, 32'h8000_0000);
        @(posedge clk); #1;
        chk("R10 next cycle uses new cfg", "flt_rd_txn", flt_rd_txn, 1'b1);
        rd_addr_valid = 1'b0; rd_addr_ready = 1'b0;
        @(posedge clk); #1;
        chk("R10 pulse ends", "flt_rd_txn", flt_rd_txn, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_lane_enables();
        t_mask();
        t_handshake();
        t_ignored();
        t_back_to_back();
        t_write_timing();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule